// File: doc/BRIEF.md
# I2C SCL Clock Divider

This block produces the serial clock timing for an I2C master from a fast system clock. A programmable prescaler first slows the system clock to a module clock. The SCL low and high phases are then timed in module clocks, each phase lasting its programmed count plus a fixed offset. The offset is 7 module clocks when the prescaler value is 0, 6 when it is 1, and 5 for any larger value. One SCL period therefore spans (P + 1) × ((L + d) + (H + d)) system clocks, where P, L and H are the prescale, low-count and high-count values. Software chooses P so that the module clock sits between 7 and 12 MHz.

Three 16-bit registers are written through a simple write port. While the core-run input is low the divider is held idle with SCL released high. Register writes made then reach the timing logic at once. Once running, new values are picked up only at the start of the next low phase, so a phase in progress is never disturbed. A separate enable pauses the timing without losing its place. The bit engine gets the SCL drive level plus one-cycle strobes on each falling and rising edge.

Top module: `scl_rate_gen`

## Requirements
- R1: While rst_n is low or core_run is low, scl_out is 1 and both strobes are 0 from the next clock on.
- R2: On the first clock with core_run and tick_en both high after being held, scl_out goes to 0 on the next cycle with scl_fall_stb high: the low phase comes first.
- R3: A low phase lasts (P+1)*(L+d) enabled clocks and a high phase (P+1)*(H+d) enabled clocks.
- R4: The offset d is 7 for P = 0, 6 for P = 1 and 5 for P >= 2.
- R5: A low or high count of 0 gives a phase of (P+1)*d clocks.
- R6: scl_fall_stb is high for exactly one cycle, the first cycle scl_out reads 0, and scl_rise_stb likewise for the first cycle it reads 1. The two strobes are never high together.
- R7: A write made while running leaves the current phases unchanged and takes effect from the next low phase.
- R8: A write made while held applies to the first low phase after release, even when made in the same cycle that core_run rises.
- R9: While tick_en is low, scl_out and the phase timing hold still, and timing resumes where it stopped.
- R10: wr_sel selects the register: 0 = prescale P, 1 = low count L, 2 = high count H. A write with wr_sel = 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; registers clear to 0 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 prescale, 1 low count, 2 high count, 3 none) |
| wr_data | input | 16 | Write data |
| core_run | input | 1 | 0 holds the divider idle and loads new values; 1 lets it run |
| tick_en | input | 1 | Count enable; 0 pauses timing |
| scl_out | output | 1 | SCL drive level (0 = pull low, 1 = release) |
| scl_fall_stb | output | 1 | One-cycle strobe at the start of each low phase |
| scl_rise_stb | output | 1 | One-cycle strobe at the start of each high phase |

## Verification
The assertions assume that wr_sel and the write data stay at defined values and that rst_n is applied once before any check counts. The phase-bound and wrap checks also rely on new values reaching the counters only at a phase boundary or while held. The stimulus keeps to this: it changes inputs only away from the clock edge and writes the prescaler mid-run only through the normal write port. It programs small counts so that many whole periods fit into each case. Pauses, holds and the ignored select code are applied both mid-phase and on phase boundaries.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

   typedef enum logic [1:0] {
      SEL_PRESCALE = 2'd0,
      SEL_LOW      = 2'd1,
      SEL_HIGH     = 2'd2,
      SEL_NONE     = 2'd3
   } reg_sel_e;

   localparam int unsigned NUM_REGS = 3;
   localparam int unsigned OFFS_W   = 3;

   // extra module clocks added to each phase, picked by the prescale value
   function automatic logic [OFFS_W-1:0] phase_offset(input logic psc_is_zero,
                                                      input logic psc_is_one);
      if (psc_is_zero)     return OFFS_W'(7);
      else if (psc_is_one) return OFFS_W'(6);
      else                 return OFFS_W'(5);
   endfunction

endpackage

// File: rtl/scl_div_regs.sv
module scl_div_regs
   import scl_div_pkg::*;
#(
   parameter int unsigned REG_W = 16
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [1:0]                       wr_sel,
   input  logic [REG_W-1:0]                 wr_data,
   input  logic                             load_act,
   output logic [NUM_REGS-1:0][REG_W-1:0]   act_q
);

   logic [NUM_REGS-1:0][REG_W-1:0] shadow_q;
   logic [NUM_REGS-1:0][REG_W-1:0] shadow_d;

   for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_slot
      assign shadow_d[gi] = (wr_en && wr_sel == 2'(gi)) ? wr_data : shadow_q[gi];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shadow_q[gi] <= '0;
            act_q[gi]    <= '0;
         end else begin
            shadow_q[gi] <= shadow_d[gi];
            if (load_act) act_q[gi] <= shadow_d[gi];
         end
      end
   end

   // R7
   act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_act |=> $stable(act_q));

endmodule

// File: rtl/scl_div_prescale.sv
module scl_div_prescale #(
   parameter int unsigned REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [REG_W-1:0] psc,
   output logic             tick
);

   logic [REG_W-1:0] cnt_q;

   assign tick = run && !clr && (cnt_q == psc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr)     cnt_q <= '0;
      else if (run)     cnt_q <= (cnt_q == psc) ? '0 : cnt_q + REG_W'(1);
   end

   // R3
   pre_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> cnt_q == '0);

   // R3
   pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= psc);

endmodule

// File: rtl/scl_div_phase.sv
module scl_div_phase
   import scl_div_pkg::*;
#(
   parameter int unsigned REG_W = 16,
   localparam int unsigned CNT_W = REG_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              en,
   input  logic              tick,
   input  logic [REG_W-1:0]  low_cnt,
   input  logic [REG_W-1:0]  high_cnt,
   input  logic [OFFS_W-1:0] offs,
   output logic              scl_q,
   output logic              fall_q,
   output logic              rise_q,
   output logic              started_q,
   output logic              reload
);

   logic [CNT_W-1:0] ph_cnt_q;
   logic [CNT_W-1:0] limit;
   logic             ph_end;

   assign limit  = {1'b0, (scl_q ? high_cnt : low_cnt)} + CNT_W'(offs);
   assign ph_end = started_q && tick && (ph_cnt_q == limit - CNT_W'(1));
   assign reload = hold || !started_q || (ph_end && scl_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started_q <= 1'b0;
         scl_q     <= 1'b1;
         fall_q    <= 1'b0;
         rise_q    <= 1'b0;
         ph_cnt_q  <= '0;
      end else if (hold) begin
         started_q <= 1'b0;
         scl_q     <= 1'b1;
         fall_q    <= 1'b0;
         rise_q    <= 1'b0;
         ph_cnt_q  <= '0;
      end else begin
         fall_q <= 1'b0;
         rise_q <= 1'b0;
         if (en && !started_q) begin
            started_q <= 1'b1;
            scl_q     <= 1'b0;
            fall_q    <= 1'b1;
            ph_cnt_q  <= '0;
         end else if (tick) begin
            if (ph_end) begin
               ph_cnt_q <= '0;
               scl_q    <= ~scl_q;
               rise_q   <= ~scl_q;
               fall_q   <= scl_q;
            end else begin
               ph_cnt_q <= ph_cnt_q + CNT_W'(1);
            end
         end
      end
   end

   // R6
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fall_q, rise_q}));

   // R6
   fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall_q |-> (!scl_q && $past(scl_q)));

   // R6
   rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_q |-> (scl_q && !$past(scl_q)));

   // R1
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (scl_q && !fall_q && !rise_q));

   // R2
   first_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && en && !started_q) |=> fall_q);

   // R9
   freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (started_q && !en && !hold) |=> ($stable(scl_q) && $stable(ph_cnt_q)));

   // R3
   phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      started_q |-> (ph_cnt_q < limit));

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
   import scl_div_pkg::*;
#(
   parameter int unsigned REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [REG_W-1:0] wr_data,
   input  logic             core_run,
   input  logic             tick_en,
   output logic             scl_out,
   output logic             scl_fall_stb,
   output logic             scl_rise_stb
);

   localparam int unsigned IDX_P = int'(SEL_PRESCALE);
   localparam int unsigned IDX_L = int'(SEL_LOW);
   localparam int unsigned IDX_H = int'(SEL_HIGH);

   if (REG_W < 4 || REG_W > 32) begin : g_width_bad
      $error("scl_rate_gen: REG_W must lie in 4..32");
   end

   logic [NUM_REGS-1:0][REG_W-1:0] act;
   logic                           load_act;
   logic                           started;
   logic                           tick;
   logic [OFFS_W-1:0]              offs;

   assign offs = phase_offset(act[IDX_P] == '0, act[IDX_P] == REG_W'(1));

   scl_div_regs #(.REG_W(REG_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .load_act (load_act),
      .act_q    (act)
   );

   scl_div_prescale #(.REG_W(REG_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!core_run || !started),
      .run   (tick_en),
      .psc   (act[IDX_P]),
      .tick  (tick)
   );

   scl_div_phase #(.REG_W(REG_W)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold      (!core_run),
      .en        (tick_en),
      .tick      (tick),
      .low_cnt   (act[IDX_L]),
      .high_cnt  (act[IDX_H]),
      .offs      (offs),
      .scl_q     (scl_out),
      .fall_q    (scl_fall_stb),
      .rise_q    (scl_rise_stb),
      .started_q (started),
      .reload    (load_act)
   );

   // R4
   offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (offs >= OFFS_W'(5)) && (offs <= OFFS_W'(7)));

endmodule

// File: tb/scl_rate_gen_bench.sv
module scl_rate_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [15:0] wr_data = '0;
   logic        core_run = 1'b0;
   logic        tick_en = 1'b0;
   logic        scl_out, scl_fall_stb, scl_rise_stb;

   always #4 clk = ~clk;

   scl_rate_gen u_scl_rate_gen (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_sel (wr_sel),
      .wr_data (wr_data), .core_run (core_run), .tick_en (tick_en),
      .scl_out (scl_out), .scl_fall_stb (scl_fall_stb), .scl_rise_stb (scl_rise_stb)
   );

   int    checks = 0;
   int    errors = 0;
   int    cycles = 0;
   bit    done = 1'b0;
   string cur_tag = "R1";

   // behavioural reference: shadow values, applied values and a countdown
   int     sh_p = 0, sh_l = 0, sh_h = 0;
   int     ap = 0, al = 0, ah = 0;
   bit     m_started = 0, m_scl = 1, m_fall = 0, m_rise = 0;
   longint rem = 0;

   function automatic int offs_of(int p);
      return (p == 0) ? 7 : ((p == 1) ? 6 : 5);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         sh_p = 0; sh_l = 0; sh_h = 0; ap = 0; al = 0; ah = 0;
         m_started = 0; m_scl = 1; m_fall = 0; m_rise = 0; rem = 0;
      end else begin
         m_fall = 0; m_rise = 0;
         if (wr_en) begin
            case (wr_sel)
               2'd0: sh_p = int'(wr_data);
               2'd1: sh_l = int'(wr_data);
               2'd2: sh_h = int'(wr_data);
               default: ;
            endcase
         end
         if (!core_run) begin
            m_started = 0; m_scl = 1;
            ap = sh_p; al = sh_l; ah = sh_h;
         end else if (!m_started) begin
            ap = sh_p; al = sh_l; ah = sh_h;
            if (tick_en) begin
               m_started = 1; m_scl = 0; m_fall = 1;
               rem = longint'(ap + 1) * longint'(al + offs_of(ap));
            end
         end else if (tick_en) begin
            rem = rem - 1;
            if (rem == 0) begin
               if (!m_scl) begin
                  m_scl = 1; m_rise = 1;
                  rem = longint'(ap + 1) * longint'(ah + offs_of(ap));
               end else begin
                  m_scl = 0; m_fall = 1;
                  ap = sh_p; al = sh_l; ah = sh_h;
                  rem = longint'(ap + 1) * longint'(al + offs_of(ap));
               end
            end
         end
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         checks++;
         if (scl_out !== m_scl || scl_fall_stb !== m_fall || scl_rise_stb !== m_rise) begin
            errors++;
            $display("FAIL %s t=%0t: scl/fall/rise actual=%0b%0b%0b expected=%0b%0b%0b",
                     cur_tag, $time, scl_out, scl_fall_stb, scl_rise_stb,
                     m_scl, m_fall, m_rise);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements): actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic cyc(input int n);
      repeat (n) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [15:0] val);
      wr_en = 1'b1; wr_sel = sel; wr_data = val;
      cyc(1);
      wr_en = 1'b0;
   endtask

   task automatic hold_and_load(input int p, input int l, input int h);
      core_run = 1'b0;
      cyc(2);
      wr(2'd0, 16'(p));
      wr(2'd1, 16'(l));
      wr(2'd2, 16'(h));
   endtask

   initial begin
      // R1: reset state and held state
      cur_tag = "R1";
      cyc(3);
      rst_n = 1'b1;
      cyc(5);

      // R4: P=0 gives d=7 (low 9, high 10)
      cur_tag = "R4";
      hold_and_load(0, 2, 3);
      core_run = 1'b1; tick_en = 1'b1;
      cyc(80);

      // R5: zero counts with P=1 give 2*6 per phase
      cur_tag = "R5";
      hold_and_load(1, 0, 0);
      core_run = 1'b1;
      cyc(80);

      // R3: P=3, d=5: low 4*6, high 4*7
      cur_tag = "R3";
      hold_and_load(3, 1, 2);
      core_run = 1'b1;
      cyc(160);

      // R7: writes while running land at the next low phase
      cur_tag = "R7";
      cyc(7);
      wr(2'd1, 16'd4);
      wr(2'd0, 16'd2);
      cyc(200);

      // R9: pause and resume, then a toggling enable
      cur_tag = "R9";
      tick_en = 1'b0;
      cyc(15);
      tick_en = 1'b1;
      cyc(20);
      for (int i = 0; i < 60; i++) begin
         tick_en = i[0];
         cyc(1);
      end
      tick_en = 1'b1;
      cyc(40);

      // R10: select code 3 writes nothing
      cur_tag = "R10";
      wr(2'd3, 16'd0);
      cyc(3);
      wr(2'd3, 16'd9);
      cyc(150);

      // R8: write in the same cycle as release
      cur_tag = "R8";
      core_run = 1'b0;
      cyc(3);
      wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'd6; core_run = 1'b1;
      cyc(1);
      wr_en = 1'b0;
      cyc(120);

      // R1: hold mid-phase, then a reset pulse
      cur_tag = "R1";
      cyc(5);
      core_run = 1'b0;
      cyc(6);
      rst_n = 1'b0;
      cyc(2);
      rst_n = 1'b1;
      cyc(3);

      // R2: release with enable low first, then enable
      cur_tag = "R2";
      tick_en = 1'b0;
      hold_and_load(0, 1, 1);
      core_run = 1'b1;
      cyc(4);
      tick_en = 1'b1;
      cyc(50);

      // R6: shortest phases, strobes back to back
      cur_tag = "R6";
      hold_and_load(0, 0, 0);
      core_run = 1'b1;
      cyc(60);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule